// File: doc/BRIEF.md
# Delay-Line Calibration Update Scheduler

This block decides when the programmable delay lines of a DDR interface get a fresh setting. An external measurement unit does the actual recomputation. The scheduler starts it with a request/done handshake, waits for the result and then does one of three things: it copies the measured value into the actual-delay register, it copies a software-supplied value into that register, or it leaves the register as it is. The measurement circuit and the analog delay lines are outside the block. They appear only as the handshake pins and a delay-value input.

A six-bit configuration write selects the behaviour. It has three stored settings: an automatic enable, an apply-inhibit bit and a two-bit period code. It also carries two one-shot commands: a software recalibration and a reapply of the held value. With the automatic enable on, a free-running counter on the system clock asks for a recomputation once per coded period. The period codes span three decades. With the automatic enable off, the one-shot commands act on demand. A recomputation is also issued when the block leaves reset and each time self-refresh is exited.

The control register has no defined value after reset. The block therefore starts nothing until the first legal write has arrived.

Top module: `dlcal_sched`

## Requirements
- R1: After reset and until the first legal configuration write, `meas_req` and `act_load` stay low, even when `sr_exit` pulses. `act_dly` resets to 0 and `cfg_err` resets to 0.
- R2: Write fields are: bit0 automatic enable, bit1 reapply-held, bit2 software recalibration, bit3 inhibit, bits5:4 period code. With the automatic enable on, rising edges of `meas_req` are spaced by PERIOD0, PERIOD1 or PERIOD2 cycles for period codes 0, 1 and 2, provided each recomputation finishes within the period.
- R3: Period code 3 is reserved. With the automatic enable on and code 3 stored, no periodic recomputation is started.
- R4: When a measured recomputation (start-up, self-refresh exit or periodic) completes and the inhibit bit is 0, `act_dly` takes the value of `meas_dly` and `act_load` pulses for one cycle.
- R5: When the inhibit bit is 1, the recomputation still runs to completion and `meas_req` drops, but `act_dly` keeps its value and `act_load` stays low.
- R6: The inhibit bit is read in the cycle that `meas_done` is seen, not at the start. A write that changes the inhibit bit during a recomputation decides the outcome.
- R7: With the automatic enable off, a software recalibration write starts a recomputation. On completion `act_dly` takes `sw_dly` as sampled in the done cycle, subject to the inhibit bit.
- R8: With the automatic enable off, a reapply-held write pulses `act_load` once without a handshake and leaves `act_dly` unchanged, whatever the inhibit bit is.
- R9: A write that sets both command bits, or that sets either command bit together with the automatic enable, is illegal. It sets the sticky `cfg_err` flag and changes no setting, starts nothing and loads nothing.
- R10: A write to the period code while the automatic enable is already on is ignored. Turning the automatic enable on restarts the period count from zero.
- R11: Only one recomputation is outstanding at a time. A period tick that falls during a recomputation is held, and the next request rises one cycle after `meas_req` falls.
- R12: Leaving reset and each `sr_exit` pulse each cause one recomputation, taken once the block is initialized.
- R13: `meas_req` stays high from its rising edge until the cycle after `meas_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Write data: enable, reapply, recal, inhibit, period code |
| sw_dly | input | DLY_W | Software-supplied delay value |
| sr_exit | input | 1 | One-cycle pulse on leaving self-refresh |
| meas_req | output | 1 | Recomputation request to the measurement unit |
| meas_done | input | 1 | Measurement unit finished, result valid |
| meas_dly | input | DLY_W | Calibrated delay from the measurement unit |
| act_dly | output | DLY_W | Actual delay applied to the delay lines |
| act_load | output | 1 | One-cycle pulse when the delay lines are (re)applied |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench builds the block with PERIOD0=8, PERIOD1=20, PERIOD2=40 and DLY_W=6. With these short periods every period code, including the reserved one, can be swept to several consecutive intervals in a few hundred cycles. The bench computes each expected spacing from the period code. The measurement responder's latency is set per test: short latencies check exact spacing, and a latency longer than the period shows the held tick, where the expected spacing is the latency plus one. Inhibit writes are placed inside an open handshake so that the sample-at-done rule can be seen at `act_dly`.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  // Write-data field positions of the configuration word
  localparam int unsigned F_AUTO  = 0;
  localparam int unsigned F_HOLD  = 1;
  localparam int unsigned F_SWCAL = 2;
  localparam int unsigned F_INH   = 3;
  localparam int unsigned F_PER_L = 4;
  localparam int unsigned CFG_W   = 6;

  typedef enum logic [1:0] {
    SRC_BOOT = 2'd0,
    SRC_AUTO = 2'd1,
    SRC_SW   = 2'd2
  } cal_src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } sched_st_e;
endpackage

// File: rtl/dlcal_cfg_reg.sv
module dlcal_cfg_reg
  import dlcal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             init_q,
  output logic             auto_q,
  output logic             inh_q,
  output logic [1:0]       sel_q,
  output logic             cmd_sw,
  output logic             cmd_hold,
  output logic             auto_start,
  output logic             err_q
);
  logic w_auto, w_hold, w_sw, w_inh, illegal;
  logic [1:0] w_sel;

  always_comb begin
    w_auto  = wdata[F_AUTO];
    w_hold  = wdata[F_HOLD];
    w_sw    = wdata[F_SWCAL];
    w_inh   = wdata[F_INH];
    w_sel   = wdata[F_PER_L +: 2];
    illegal = (w_hold & w_sw) | (w_auto & (w_hold | w_sw));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q     <= 1'b0;
      auto_q     <= 1'b0;
      inh_q      <= 1'b0;
      sel_q      <= 2'd0;
      cmd_sw     <= 1'b0;
      cmd_hold   <= 1'b0;
      auto_start <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cmd_sw     <= 1'b0;
      cmd_hold   <= 1'b0;
      auto_start <= 1'b0;
      if (we) begin
        if (illegal) begin
          err_q <= 1'b1;
        end else begin
          init_q     <= 1'b1;
          inh_q      <= w_inh;
          auto_q     <= w_auto;
          if (!auto_q) sel_q <= w_sel;
          cmd_sw     <= w_sw;
          cmd_hold   <= w_hold;
          auto_start <= w_auto & ~auto_q;
        end
      end
    end
  end
endmodule

// File: rtl/dlcal_period_timer.sv
module dlcal_period_timer #(
  parameter int unsigned PERIOD0 = 10000,
  parameter int unsigned PERIOD1 = 1000000,
  parameter int unsigned PERIOD2 = 10000000,
  localparam int unsigned CNT_W  = $clog2(PERIOD2 + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'(PERIOD0 - 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(PERIOD1 - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(PERIOD2 - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             valid_sel;

  always_comb begin
    valid_sel = 1'b1;
    case (sel)
      2'd0:    last = LAST0;
      2'd1:    last = LAST1;
      2'd2:    last = LAST2;
      default: begin
        last      = '0;
        valid_sel = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart || !valid_sel) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dlcal_update_fsm.sv
module dlcal_update_fsm
  import dlcal_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             auto_en,
  input  logic             inhibit,
  input  logic             cmd_sw,
  input  logic             cmd_hold,
  input  logic             tick,
  input  logic             sr_exit,
  input  logic [DLY_W-1:0] sw_dly,
  input  logic             meas_done,
  input  logic [DLY_W-1:0] meas_dly,
  output logic             meas_req,
  output logic [DLY_W-1:0] act_dly,
  output logic             act_load
);
  sched_st_e st;
  cal_src_e  src;
  logic pend_boot, pend_sw, pend_hold, pend_auto;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      src       <= SRC_BOOT;
      pend_boot <= 1'b1;
      pend_sw   <= 1'b0;
      pend_hold <= 1'b0;
      pend_auto <= 1'b0;
      meas_req  <= 1'b0;
      act_dly   <= '0;
      act_load  <= 1'b0;
    end else begin
      act_load <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (init) begin
            if (pend_boot) begin
              pend_boot <= 1'b0;
              src       <= SRC_BOOT;
              meas_req  <= 1'b1;
              st        <= ST_WAIT;
            end else if (pend_sw) begin
              pend_sw  <= 1'b0;
              src      <= SRC_SW;
              meas_req <= 1'b1;
              st       <= ST_WAIT;
            end else if (pend_hold) begin
              pend_hold <= 1'b0;
              act_load  <= 1'b1;
            end else if (pend_auto) begin
              pend_auto <= 1'b0;
              src       <= SRC_AUTO;
              meas_req  <= 1'b1;
              st        <= ST_WAIT;
            end
          end
        end
        default: begin
          if (meas_done) begin
            meas_req <= 1'b0;
            st       <= ST_IDLE;
            if (!inhibit) begin
              act_load <= 1'b1;
              act_dly  <= (src == SRC_SW) ? sw_dly : meas_dly;
            end
          end
        end
      endcase
      if (sr_exit)  pend_boot <= 1'b1;
      if (cmd_sw)   pend_sw   <= 1'b1;
      if (cmd_hold) pend_hold <= 1'b1;
      if (tick)     pend_auto <= 1'b1;
      if (!auto_en) pend_auto <= 1'b0;
    end
  end
endmodule

// File: rtl/dlcal_sched.sv
module dlcal_sched
  import dlcal_pkg::*;
#(
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned PERIOD0 = 10000,
  parameter int unsigned PERIOD1 = 1000000,
  parameter int unsigned PERIOD2 = 10000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_wdata,
  input  logic [DLY_W-1:0] sw_dly,
  input  logic             sr_exit,
  output logic             meas_req,
  input  logic             meas_done,
  input  logic [DLY_W-1:0] meas_dly,
  output logic [DLY_W-1:0] act_dly,
  output logic             act_load,
  output logic             cfg_err
);
  logic       init_q, auto_q, inh_q, cmd_sw, cmd_hold, auto_start, tick_q;
  logic [1:0] sel_q;

  dlcal_cfg_reg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .init_q     (init_q),
    .auto_q     (auto_q),
    .inh_q      (inh_q),
    .sel_q      (sel_q),
    .cmd_sw     (cmd_sw),
    .cmd_hold   (cmd_hold),
    .auto_start (auto_start),
    .err_q      (cfg_err)
  );

  dlcal_period_timer #(
    .PERIOD0 (PERIOD0),
    .PERIOD1 (PERIOD1),
    .PERIOD2 (PERIOD2)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (auto_q),
    .restart (auto_start),
    .sel     (sel_q),
    .tick    (tick_q)
  );

  dlcal_update_fsm #(
    .DLY_W (DLY_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .init      (init_q),
    .auto_en   (auto_q),
    .inhibit   (inh_q),
    .cmd_sw    (cmd_sw),
    .cmd_hold  (cmd_hold),
    .tick      (tick_q),
    .sr_exit   (sr_exit),
    .sw_dly    (sw_dly),
    .meas_done (meas_done),
    .meas_dly  (meas_dly),
    .meas_req  (meas_req),
    .act_dly   (act_dly),
    .act_load  (act_load)
  );
endmodule

// File: rtl/dlcal_sched_chk.sv
module dlcal_sched_chk #(
  parameter int unsigned DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             meas_req,
  input logic             meas_done,
  input logic             act_load,
  input logic [DLY_W-1:0] act_dly,
  input logic             cfg_err,
  input logic             init,
  input logic [1:0]       sel,
  input logic             tick
);
  // R13: request held until done is seen
  p_req_held_r13: assert property (@(posedge clk) disable iff (rst)
    (meas_req && !meas_done) |=> meas_req);

  // R1: nothing requested before initialization
  p_idle_uninit_r1: assert property (@(posedge clk) disable iff (rst)
    !init |-> (!meas_req && !act_load));

  // R4/R5: actual delay only moves together with a load pulse
  p_dly_with_load_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_dly) |-> act_load);

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R3: reserved period code never ticks
  p_no_tick_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'd3 && $past(sel) == 2'd3) |-> !tick);

  // R11: a load never coincides with an open request
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    act_load |-> !meas_req);
endmodule

bind dlcal_sched dlcal_sched_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .meas_req  (meas_req),
  .meas_done (meas_done),
  .act_load  (act_load),
  .act_dly   (act_dly),
  .cfg_err   (cfg_err),
  .init      (init_q),
  .sel       (sel_q),
  .tick      (tick_q)
);

// File: tb/test_dlcal_sched.sv
`timescale 1ns/1ps
module test_dlcal_sched;
  localparam int DW = 6;
  localparam int P0 = 8;
  localparam int P1 = 20;
  localparam int P2 = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [DW-1:0] sw_dly = '0;
  logic sr_exit = 1'b0;
  logic meas_req;
  logic meas_done = 1'b0;
  logic [DW-1:0] meas_dly = '0;
  logic [DW-1:0] act_dly;
  logic act_load;
  logic cfg_err;

  int checks = 0;
  int fails = 0;
  int resp_delay = 3;
  int resp_val = 0;
  int cyc = 0;
  int last_rise = 0;
  int iv = 0;
  int rises = 0;
  int loads = 0;
  bit req_prev = 1'b0;

  always #2.5 clk = ~clk;

  dlcal_sched #(.DLY_W(DW), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2)) i_dlcal_sched (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sw_dly(sw_dly),
    .sr_exit(sr_exit), .meas_req(meas_req), .meas_done(meas_done), .meas_dly(meas_dly),
    .act_dly(act_dly), .act_load(act_load), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (meas_req && !req_prev) begin
        iv = cyc - last_rise;
        last_rise = cyc;
        rises = rises + 1;
      end
      if (act_load) loads = loads + 1;
    end
    req_prev = meas_req;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (meas_req && !rst) begin
        repeat (resp_delay - 1) @(negedge clk);
        meas_dly = DW'(resp_val);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input bit a, input bit h, input bit s, input bit i, input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {p, i, s, h, a};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (meas_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_rise();
    int r0;
    r0 = rises;
    while (rises == r0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    int r, l;
    int per[3];
    per[0] = P0; per[1] = P1; per[2] = P2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!meas_req && !act_load, "R1 reset outputs idle", int'(meas_req), 0);
    chk(act_dly == 0, "R1 act_dly reset", int'(act_dly), 0);
    chk(!cfg_err, "R1 cfg_err reset", int'(cfg_err), 0);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    repeat (30) @(negedge clk);
    chk(rises == 0 && loads == 0, "R1 no activity before first write", rises + loads, 0);

    // R12/R4: start-up recomputation applies measured value
    resp_delay = 3; resp_val = 21;
    wr(0, 0, 0, 0, 0);
    wait_idle();
    chk(rises == 1, "R12 start-up recompute issued once", rises, 1);
    chk(act_dly == 21, "R4 measured value applied", int'(act_dly), 21);

    // R5/R12: self-refresh exit with inhibit set
    wr(0, 0, 0, 1, 0);
    r = rises; l = loads; resp_val = 9;
    @(negedge clk); sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    wait_idle();
    chk(rises == r + 1, "R12 self-refresh exit recompute", rises - r, 1);
    chk(act_dly == 21 && loads == l, "R5 inhibit keeps act_dly", int'(act_dly), 21);
    chk(!meas_req, "R5 handshake completed", int'(meas_req), 0);

    // R7: software recalibration
    sw_dly = 33; resp_val = 40;
    wr(0, 0, 1, 0, 0);
    wait_idle();
    chk(act_dly == 33, "R7 sw value applied", int'(act_dly), 33);
    r = rises; sw_dly = 5;
    wr(0, 0, 1, 1, 0);
    wait_idle();
    chk(rises == r + 1 && act_dly == 33, "R7 sw recal inhibited", int'(act_dly), 33);

    // R8: reapply held value ignores inhibit
    r = rises; l = loads;
    wr(0, 1, 0, 1, 0);
    repeat (5) @(negedge clk);
    chk(loads == l + 1, "R8 reapply pulses load", loads - l, 1);
    chk(rises == r && act_dly == 33, "R8 no handshake, value held", int'(act_dly), 33);

    // R6: inhibit sampled at done
    resp_delay = 12; sw_dly = 44;
    wr(0, 0, 1, 0, 0);
    while (!meas_req) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(0, 0, 0, 1, 0);
    wait_idle();
    chk(act_dly == 33, "R6 late inhibit blocks apply", int'(act_dly), 33);
    wr(0, 0, 1, 1, 0);
    while (!meas_req) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(0, 0, 0, 0, 0);
    wait_idle();
    chk(act_dly == 44, "R6 late clear allows apply", int'(act_dly), 44);

    // R9: illegal combinations
    r = rises; l = loads;
    wr(0, 1, 1, 0, 0);
    repeat (6) @(negedge clk);
    chk(cfg_err == 1'b1, "R9 error flag set", int'(cfg_err), 1);
    chk(rises == r && loads == l, "R9 no action on illegal write", rises - r + loads - l, 0);
    wr(1, 0, 1, 0, 0);
    repeat (P0 * 3) @(negedge clk);
    chk(rises == r && cfg_err, "R9 auto+recal rejected, flag sticky", rises - r, 0);

    // R2: period sweep
    resp_delay = 2;
    for (int s = 0; s < 3; s++) begin
      wr(0, 0, 0, 1, 2'(s));
      repeat (3) @(negedge clk);
      wr(1, 0, 0, 1, 2'(s));
      wait_rise();
      for (int k = 0; k < 3; k++) begin
        wait_rise();
        chk(iv == per[s], $sformatf("R2 interval code %0d", s), iv, per[s]);
      end
    end

    // R10: period write ignored while enabled
    wr(0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    wr(1, 0, 0, 1, 0);
    wait_rise();
    wr(1, 0, 0, 1, 2);
    wait_rise();
    for (int k = 0; k < 2; k++) begin
      wait_rise();
      chk(iv == P0, "R10 period unchanged by write", iv, P0);
    end

    // R3: reserved code
    wr(0, 0, 0, 1, 3);
    repeat (6) @(negedge clk);
    r = rises;
    wr(1, 0, 0, 1, 3);
    repeat (P2 * 3) @(negedge clk);
    chk(rises == r, "R3 reserved code no recompute", rises - r, 0);

    // R11: tick held while busy
    wr(0, 0, 0, 1, 0);
    repeat (6) @(negedge clk);
    resp_delay = 20;
    wr(1, 0, 0, 1, 0);
    wait_rise();
    for (int k = 0; k < 2; k++) begin
      wait_rise();
      chk(iv == resp_delay + 1, "R11 held tick issued after done", iv, resp_delay + 1);
    end
    wr(0, 0, 0, 1, 0);
    repeat (30) @(negedge clk);
    chk(!meas_req, "R13 request released", int'(meas_req), 0);
    report();
  end
endmodule